// File: doc/BRIEF.md
# Three-Read Register File Built from Dual-Read Banks

This block is a general-purpose register file of 32 words of 32 bits. It has three read ports that work independently and one write port. The storage primitive behind it has only two read ports and one write port. The file therefore holds two identical copies of its contents. Every write is broadcast to both copies in the same clock edge, and the three read ports are split across the copies: ports A and B read copy 0, and port C reads copy 1.

A parameter chooses how each copy is built:

- **Inferred style:** a behavioural array that an FPGA flow can map onto distributed or block storage.
- **Macro style:** a structural array of enabled word cells behind a wrapper. It stands in for a hard-macro bank that a physical flow would swap in.

Both styles give the same port behaviour on every cycle. Reads are combinational from the address. A write takes effect at the rising clock edge. There is no write-to-read bypass. Every word powers up as zero. While the synchronous active-high reset is asserted, writes are ignored, and the stored contents are kept because reset does not clear them.

Top module: `regfile_3r1w`

## Requirements
- R1: Before any write, every one of the 32 words reads as zero on all three read ports.
- R2: When `wr_en` is 1 and `rst` is 0 at a rising clock edge, the word at `wr_addr` takes `wr_data`. Every read port that addresses it shows the new value after that edge.
- R3: The three read ports are independent. Any combination of addresses gives each port the contents of its own address, and this includes two or three ports on the same address.
- R4: Reads are combinational. A change of a read address alone changes that port's data in the same cycle, with no clock edge needed.
- R5: A read of the word being written in the same cycle returns the old contents until the write edge. There is no bypass.
- R6: While `wr_en` is 0, no word changes, so read data for an unchanged address holds steady.
- R7: While `rst` is 1, a write request has no effect on any word, and reset does not clear the stored contents.
- R8: The inferred style (`STYLE` = 0) and the macro style (`STYLE` = 1) give identical read data on every cycle for identical inputs.
- R9: Word 0 is ordinary storage. It can be written and read back like any other word.
- R10: Both internal banks always hold the same contents, so bank 1 read at any address matches bank 0 read at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes while high |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 32 | Data to write |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data (combinational) |
| rd_addr_c | input | 5 | Read port C address |
| rd_data_c | output | 32 | Read port C data (combinational) |

## Verification
The bench first sweeps all 32 addresses before any write, which shows the power-up zero state. It then writes a distinct pattern to each word, with word 0 included, and reads every word back on each port; this exposes address decoding faults and any port wired to the wrong bank. Directed collisions follow:

- all three ports on the same address;
- a read of the word being written in the same cycle, which separates the old-data behaviour from a bypass;
- writes held under reset and writes with the enable low, which must leave the contents as they were.

A long run of random traffic then drives both storage styles side by side against a behavioural reference array, which shows that the two styles cannot be told apart.

// File: rtl/rf3_pkg.sv
package rf3_pkg;

  typedef enum logic {
    STORE_INFERRED = 1'b0,
    STORE_MACRO    = 1'b1
  } store_style_e;

  // Read ports the file must offer and read ports one bank provides.
  localparam int unsigned RF_READ_PORTS   = 3;
  localparam int unsigned BANK_READ_PORTS = 2;
  localparam int unsigned RF_BANKS =
    (RF_READ_PORTS + BANK_READ_PORTS - 1) / BANK_READ_PORTS;

endpackage

// File: rtl/rf_word_cell.sv
// One enabled storage word: the leaf of the macro-style bank.
module rf_word_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] word_q = '0;

  always_ff @(posedge clk) begin
    if (load) word_q <= d;
  end

  assign q = word_q;

endmodule

// File: rtl/rf_bank_2r1w.sv
// Two-read / one-write bank; STYLE picks behavioural or cell-built storage.
module rf_bank_2r1w
  import rf3_pkg::*;
#(
  parameter int unsigned  DATA_W = 32,
  parameter int unsigned  ADDR_W = 5,
  parameter store_style_e STYLE  = STORE_INFERRED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  output logic [DATA_W-1:0] rdata0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata1
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  generate
    if (STYLE == STORE_INFERRED) begin : g_inferred
      logic [DATA_W-1:0] mem [DEPTH];

      initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      end

      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
      end

      assign rdata0 = mem[raddr0];
      assign rdata1 = mem[raddr1];

      // R2: a granted write is present in the array after the edge
      a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));

    end else begin : g_macro
      logic [DATA_W-1:0] cell_q [DEPTH];
      logic [DEPTH-1:0]  load_vec;

      always_comb begin
        load_vec = '0;
        load_vec[waddr] = we;
      end

      for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] q_w;
        rf_word_cell #(.DATA_W(DATA_W)) u_cell (
          .clk  (clk),
          .load (load_vec[w]),
          .d    (wdata),
          .q    (q_w)
        );
        assign cell_q[w] = q_w;
      end

      assign rdata0 = cell_q[raddr0];
      assign rdata1 = cell_q[raddr1];

      // R2: write decode hits exactly the addressed word
      a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
        $countones(load_vec) == (we ? 1 : 0));

      a_r2_write_lands_cell: assert property (@(posedge clk) disable iff (rst)
        we |=> cell_q[$past(waddr)] == $past(wdata));
    end
  endgenerate

endmodule

// File: rtl/regfile_3r1w.sv
// Three-read / one-write register file made of replicated 2R1W banks.
module regfile_3r1w
  import rf3_pkg::*;
#(
  parameter int unsigned  DATA_W = 32,
  parameter int unsigned  ADDR_W = 5,
  parameter store_style_e STYLE  = STORE_MACRO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic [ADDR_W-1:0] rd_addr_c,
  output logic [DATA_W-1:0] rd_data_c
);

  logic              wr_grant;
  logic [ADDR_W-1:0] bank_ra [RF_BANKS][BANK_READ_PORTS];
  logic [DATA_W-1:0] bank_rd [RF_BANKS][BANK_READ_PORTS];

  // Broadcast write: every bank sees the same grant, address and data.
  assign wr_grant = wr_en && !rst;

  // Port map: A,B -> bank 0; C -> bank 1. The spare bank-1 slot mirrors
  // port A so the two copies can be compared.
  always_comb begin
    bank_ra[0][0] = rd_addr_a;
    bank_ra[0][1] = rd_addr_b;
    bank_ra[1][0] = rd_addr_c;
    bank_ra[1][1] = rd_addr_a;
  end

  generate
    for (genvar b = 0; b < RF_BANKS; b++) begin : g_bank
      rf_bank_2r1w #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .STYLE  (STYLE)
      ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_grant),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr0 (bank_ra[b][0]),
        .rdata0 (bank_rd[b][0]),
        .raddr1 (bank_ra[b][1]),
        .rdata1 (bank_rd[b][1])
      );
    end
  endgenerate

  assign rd_data_a = bank_rd[0][0];
  assign rd_data_b = bank_rd[0][1];
  assign rd_data_c = bank_rd[1][0];

  // R10: the two replicas return the same word for the same address
  a_r10_banks_agree: assert property (@(posedge clk) disable iff (rst)
    bank_rd[1][1] == bank_rd[0][0]);

  // R6: with no write granted and a steady address, port A holds its data
  a_r6_read_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_grant) && $stable(rd_addr_a)) |-> $stable(rd_data_a));

  // R3: port C agrees with port A whenever both point at the same word
  a_r3_c_matches_a: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_c == rd_addr_a) |-> (rd_data_c == rd_data_a));

endmodule

// File: tb/regfile_3r1w_bench.sv
module regfile_3r1w_bench;
  import rf3_pkg::*;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, ra = '0, rb = '0, rc = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] da_m, db_m, dc_m, da_i, db_i, dc_i;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NW];
  bit done = 0;

  always #10 clk = ~clk;

  regfile_3r1w #(.DATA_W(DW), .ADDR_W(AW), .STYLE(STORE_MACRO)) u_regfile_3r1w (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(ra), .rd_data_a(da_m), .rd_addr_b(rb), .rd_data_b(db_m),
    .rd_addr_c(rc), .rd_data_c(dc_m));

  regfile_3r1w #(.DATA_W(DW), .ADDR_W(AW), .STYLE(STORE_INFERRED)) u_regfile_3r1w_inf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(ra), .rd_data_a(da_i), .rd_addr_b(rb), .rd_data_b(db_i),
    .rd_addr_c(rc), .rd_data_c(dc_i));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Compare all six outputs against the model (both styles: R8).
  task automatic check_ports(input string req);
    chk(req, da_m, model[ra]); chk(req, db_m, model[rb]); chk(req, dc_m, model[rc]);
    chk({req, "/R8"}, da_i, model[ra]); chk({req, "/R8"}, db_i, model[rb]);
    chk({req, "/R8"}, dc_i, model[rc]);
  endtask

  // Set inputs after a falling edge, check mid-low phase, then take the edge.
  task automatic cycle(input logic r, input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic [AW-1:0] a,
                       input logic [AW-1:0] b, input logic [AW-1:0] c, input string req);
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; ra = a; rb = b; rc = c;
    #5;
    check_ports(req);
    @(posedge clk);
    if (we && !r) model[wa] = wd;
  endtask

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '0;
    // R1 / R7: reset held with write requests; contents stay zero
    for (int i = 0; i < NW; i++)
      cycle(1'b1, 1'b1, AW'(i), 32'hDEAD_0000 | i, AW'(i), AW'(NW-1-i), AW'(i), "R1_R7");
    for (int i = 0; i < NW; i++)
      cycle(1'b0, 1'b0, '0, '1, AW'(i), AW'(i), AW'(i), "R1");
    // R2 / R9: fill every word with a distinct pattern, word 0 included
    for (int i = 0; i < NW; i++)
      cycle(1'b0, 1'b1, AW'(i), 32'hA5000000 ^ (i * 32'h01010101), '0, '0, '0, "R2_R9");
    // R3: read back across ports, including all-equal addresses
    for (int i = 0; i < NW; i++)
      cycle(1'b0, 1'b0, '0, '0, AW'(i), AW'(i+7), AW'(i+13), "R3");
    for (int i = 0; i < NW; i++)
      cycle(1'b0, 1'b0, '0, '0, AW'(i), AW'(i), AW'(i), "R3");
    // R4: change only the address within one low phase
    @(negedge clk);
    wr_en = 0; ra = 5'd3; rb = 5'd4; rc = 5'd5; #3; check_ports("R4");
    ra = 5'd9; rb = 5'd10; rc = 5'd11; #3; check_ports("R4");
    @(posedge clk);
    // R5: read of the word being written returns the old value
    cycle(1'b0, 1'b1, 5'd6, 32'h1234_5678, 5'd6, 5'd6, 5'd6, "R5");
    cycle(1'b0, 1'b0, '0, '0, 5'd6, 5'd6, 5'd6, "R5");
    chk("R5", da_m, 32'h1234_5678);
    // R6: enable low leaves contents alone
    cycle(1'b0, 1'b0, 5'd6, 32'hFFFF_0000, 5'd6, 5'd6, 5'd6, "R6");
    cycle(1'b0, 1'b0, '0, '0, 5'd6, 5'd6, 5'd6, "R6");
    chk("R6", dc_m, 32'h1234_5678);
    // R7: reset keeps existing contents and blocks a write
    cycle(1'b1, 1'b1, 5'd6, 32'h0BAD_0BAD, 5'd6, 5'd6, 5'd6, "R7");
    cycle(1'b0, 1'b0, '0, '0, 5'd6, 5'd6, 5'd6, "R7");
    chk("R7", db_i, 32'h1234_5678);
    // R9: word 0 overwritten and read back on all ports
    cycle(1'b0, 1'b1, 5'd0, 32'hC0DE_0000, 5'd1, 5'd2, 5'd3, "R9");
    cycle(1'b0, 1'b0, '0, '0, 5'd0, 5'd0, 5'd0, "R9");
    chk("R9", dc_i, 32'hC0DE_0000);
    // R8: random traffic, both styles against the model
    for (int n = 0; n < 3000; n++)
      cycle(($urandom % 40) == 0, $urandom[0], AW'($urandom), $urandom,
            AW'($urandom), AW'($urandom), AW'($urandom), "R8");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule